// File: doc/BRIEF.md
# Electronic Shutter Setting Capture

This block turns three slow pins into an electronic-shutter setting for a CCD timing pulse generator. The setting is a 2-bit shutter mode and a 9-bit load value. A format-select pin chooses how the three pins are read.

With the format select low, the pins form a serial port: pin A is the strobe, pin B is the shift clock and pin C is the data. A 12-bit frame is shifted in on rising edges of pin B. The frame holds the load value least-significant bit first, then two mode bits, then a dummy bit. While the strobe is low, the shifted frame is copied into a holding register. With the format select high, the pins are a 3-bit code that picks one of eight fixed high-speed settings. These are given as load values, so the pulse generator sees the same interface in both formats.

An enable pin overrides everything else and reports the shutter as off. All pins are sampled by the system clock through two-flop synchronizers. The decoded setting is registered before it leaves the block.

Top module: `shutter_cfg_capture`

## Requirements
- R1: After reset, shut_mode_o is 2'b11 (off) and shut_load_o is 0.
- R2: With fmt_par_i low, pin C is sampled on each rising edge of pin B. The frame bit order is: load bit 0 first through load bit 8, then mode bit M1, then mode bit M2, then one dummy bit.
- R3: The mode code {M1,M2} is output unchanged on shut_mode_o: 2'b00 is flickerless, 2'b01 is high-speed, 2'b10 is low-speed, 2'b11 is off.
- R4: While the strobe (pin A) stays high, shifting frames in does not change either output.
- R5: While the strobe is low in serial format, the last 12 shifted bits are committed. The committed setting reaches the outputs on the fourth rising clock edge after the strobe falls, and not on the third.
- R6: A frame that carries the low-speed mode with load value 0x1FF is rejected at commit, and the previous setting stays. Load 0x1FF with any other mode is accepted.
- R7: With fmt_par_i high, code {C,B,A} selects high-speed mode (2'b01) with load value 0x196, 0x176, 0x137, 0x118, 0x108, 0x100, 0x0FC or 0x0FA for codes 0 to 7. The result appears on the third rising edge after the pins change, and not on the second.
- R8: With enable_i low, the outputs show off (2'b11) with load 0 by the third rising edge, whatever the format or the pins. The held serial setting is kept.
- R9: Whenever the reported mode is off, the reported load value is 0.
- R10: The holding register keeps its contents while the block is in parallel format. Returning to serial format shows that setting again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_par_i | input | 1 | Format select: 0 serial, 1 parallel |
| enable_i | input | 1 | Shutter enable; low forces off |
| pin_a_i | input | 1 | Serial strobe / parallel code bit 0 |
| pin_b_i | input | 1 | Serial clock / parallel code bit 1 |
| pin_c_i | input | 1 | Serial data / parallel code bit 2 |
| shut_mode_o | output | 2 | Shutter mode code |
| shut_load_o | output | 9 | Load value for the pulse generator |

## Verification
Every pin goes through two synchronizer flops, so different inputs take different numbers of edges to reach the outputs. A parallel code change or an enable change reaches the output register on the third rising edge. A strobe fall needs a fourth edge, because it passes through the holding register first. A serial data bit is taken one edge after pin B's synchronized rise. The bench drives pins on falling edges and samples 5 ns after a rising edge. At the latency boundaries it checks both the edge before the due edge (old value) and the due edge itself (new value). Elsewhere it waits well past the due edge.

// File: rtl/shutter_cfg_pkg.sv
package shutter_cfg_pkg;

    parameter int unsigned LOAD_W  = 9;
    parameter int unsigned MODE_W  = 2;
    parameter int unsigned FRAME_W = LOAD_W + MODE_W + 1;
    parameter int unsigned CODE_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        SHM_FLICKERLESS = 2'b00,
        SHM_FAST        = 2'b01,
        SHM_SLOW        = 2'b10,
        SHM_OFF         = 2'b11
    } shm_e;

    typedef struct packed {
        shm_e              mode;
        logic [LOAD_W-1:0] load;
    } shut_cfg_t;

    localparam shut_cfg_t CFG_OFF = '{mode: SHM_OFF, load: '0};

    // Fixed high-speed presets, slowest first, fastest last.
    function automatic logic [LOAD_W-1:0] preset_load(input logic [CODE_W-1:0] code);
        logic [LOAD_W-1:0] v;
        case (code)
            3'd0:    v = 9'h196;
            3'd1:    v = 9'h176;
            3'd2:    v = 9'h137;
            3'd3:    v = 9'h118;
            3'd4:    v = 9'h108;
            3'd5:    v = 9'h100;
            3'd6:    v = 9'h0FC;
            default: v = 9'h0FA;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/shutter_pin_sync.sv
module shutter_pin_sync #(
    parameter int unsigned N       = 5,
    parameter int unsigned STAGES  = 2,
    parameter logic [N-1:0] RST_LVL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o
);

    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], pin_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_LVL[g]}};
            else        chain_q <= chain_d;
        end

        assign lvl_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/shutter_serial_reg.sv
module shutter_serial_reg
    import shutter_cfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      shift_i,
    input  logic      bit_i,
    input  logic      commit_i,
    output shut_cfg_t hold_o
);

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        shut_cfg_t          hold;
    } sreg_t;

    sreg_t     st_d, st_q;
    shut_cfg_t cand;

    always_comb begin
        st_d      = st_q;
        cand.load = st_q.frame[LOAD_W-1:0];
        cand.mode = shm_e'({st_q.frame[LOAD_W], st_q.frame[LOAD_W+1]});
        if (shift_i) begin
            st_d.frame = {bit_i, st_q.frame[FRAME_W-1:1]};
        end
        if (commit_i && !(cand.mode == SHM_SLOW && cand.load == '1)) begin
            st_d.hold = cand;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.frame <= '1;
            st_q.hold  <= CFG_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = st_q.hold;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(st_q.hold)); // R4

    AST_NO_SLOW_ALLONES: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.hold.mode == SHM_SLOW && st_q.hold.load == '1)); // R6

endmodule

// File: rtl/shutter_par_decode.sv
module shutter_par_decode
    import shutter_cfg_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output shut_cfg_t         cfg_o
);

    always_comb begin
        cfg_o.mode = SHM_FAST;
        cfg_o.load = preset_load(code_i);
    end

endmodule

// File: rtl/shutter_cfg_capture.sv
module shutter_cfg_capture
    import shutter_cfg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fmt_par_i,
    input  logic       enable_i,
    input  logic       pin_a_i,
    input  logic       pin_b_i,
    input  logic       pin_c_i,
    output logic [1:0] shut_mode_o,
    output logic [8:0] shut_load_o
);

    localparam int unsigned NPIN  = 5;
    localparam int unsigned IX_A  = 0;
    localparam int unsigned IX_B  = 1;
    localparam int unsigned IX_C  = 2;
    localparam int unsigned IX_EN = 3;
    localparam int unsigned IX_FM = 4;
    localparam logic [NPIN-1:0] RST_LVL = 5'b00001;

    typedef struct packed {
        shut_cfg_t cfg;
        logic      b_prev;
    } top_t;

    logic [NPIN-1:0] lvl;
    logic            serial_mode, shift, commit;
    shut_cfg_t       hold_cfg, par_cfg, sel;
    top_t            st_d, st_q;

    shutter_pin_sync #(
        .N       (NPIN),
        .STAGES  (SYNC_STAGES),
        .RST_LVL (RST_LVL)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({fmt_par_i, enable_i, pin_c_i, pin_b_i, pin_a_i}),
        .lvl_o (lvl)
    );

    assign serial_mode = !lvl[IX_FM];
    assign shift       = serial_mode && lvl[IX_B] && !st_q.b_prev;
    assign commit      = serial_mode && !lvl[IX_A];

    shutter_serial_reg sreg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_i  (shift),
        .bit_i    (lvl[IX_C]),
        .commit_i (commit),
        .hold_o   (hold_cfg)
    );

    shutter_par_decode pdec_i (
        .code_i ({lvl[IX_C], lvl[IX_B], lvl[IX_A]}),
        .cfg_o  (par_cfg)
    );

    always_comb begin
        st_d        = st_q;
        st_d.b_prev = lvl[IX_B];
        sel         = serial_mode ? hold_cfg : par_cfg;
        if (!lvl[IX_EN] || sel.mode == SHM_OFF) begin
            st_d.cfg = CFG_OFF;
        end else begin
            st_d.cfg = sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg    <= CFG_OFF;
            st_q.b_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shut_mode_o = st_q.cfg.mode;
    assign shut_load_o = st_q.cfg.load;

    AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl[IX_EN] |=> shut_mode_o == 2'b11); // R8

    AST_PAR_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl[IX_EN] && lvl[IX_FM]) |=> shut_mode_o == 2'b01); // R7

    AST_OFF_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        shut_mode_o == 2'b11 |-> shut_load_o == '0); // R9

    AST_SHIFT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> !shift); // R2

endmodule

// File: tb/shutter_cfg_capture_tb.sv
module shutter_cfg_capture_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fmt_par_i = 1'b0;
    logic       enable_i = 1'b0;
    logic       pin_a_i = 1'b1;
    logic       pin_b_i = 1'b0;
    logic       pin_c_i = 1'b0;
    logic [1:0] shut_mode_o;
    logic [8:0] shut_load_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [1:0] exp_mode;
    logic [8:0] exp_load;

    always #10 clk = ~clk;

    shutter_cfg_capture dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fmt_par_i   (fmt_par_i),
        .enable_i    (enable_i),
        .pin_a_i     (pin_a_i),
        .pin_b_i     (pin_b_i),
        .pin_c_i     (pin_c_i),
        .shut_mode_o (shut_mode_o),
        .shut_load_o (shut_load_o)
    );

    task automatic check(input logic [1:0] em, input logic [8:0] el, input string tag);
        n_vec++;
        if (shut_mode_o !== em || shut_load_o !== el) begin
            n_fail++;
            $display("FAIL %s: mode=%b load=%h expected mode=%b load=%h",
                     tag, shut_mode_o, shut_load_o, em, el);
        end
    endtask

    // wait n rising edges, then sample point 5 ns later
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic to_negedge();
        @(negedge clk);
    endtask

    function automatic logic [8:0] preset(input int k);
        logic [8:0] t [8] = '{9'h196, 9'h176, 9'h137, 9'h118,
                              9'h108, 9'h100, 9'h0FC, 9'h0FA};
        return t[k];
    endfunction

    task automatic send_word(input logic [8:0] ld, input logic m1, input logic m2);
        logic [11:0] fr;
        fr = {1'b0, m2, m1, ld};
        to_negedge();
        pin_a_i = 1'b1;
        for (int i = 0; i < 12; i++) begin
            pin_c_i = fr[i];
            repeat (3) to_negedge();
            pin_b_i = 1'b1;
            repeat (3) to_negedge();
            pin_b_i = 1'b0;
            repeat (3) to_negedge();
        end
        check(exp_mode, exp_load, "R4 strobe high, frame shifted, output held");
        to_negedge();
        pin_a_i = 1'b0;
        edges(3);
        check(exp_mode, exp_load, "R5 third edge after strobe fall still old");
        if (!(m1 && !m2 && ld == 9'h1FF)) begin
            exp_mode = {m1, m2};
            exp_load = ({m1, m2} == 2'b11) ? 9'h000 : ld;
        end
        edges(1);
        check(exp_mode, exp_load,
              (m1 && !m2 && ld == 9'h1FF) ? "R6 slow 0x1FF rejected" :
              "R2 R3 R5 R9 serial commit");
        to_negedge();
        pin_a_i = 1'b1;
        repeat (4) to_negedge();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [8:0] loads [6] = '{9'h000, 9'h0FA, 9'h155, 9'h1FE, 9'h1FF, 9'h0AA};
        logic [1:0] saved_m;
        logic [8:0] saved_l;

        repeat (3) @(posedge clk);
        #5;
        check(2'b11, 9'h000, "R1 reset state");
        to_negedge();
        rst_n = 1'b1;
        edges(2);
        check(2'b11, 9'h000, "R1 after reset release");

        exp_mode = 2'b11;
        exp_load = 9'h000;
        to_negedge();
        enable_i = 1'b1;
        repeat (5) to_negedge();

        // serial sweep over every mode and several load values
        for (int m = 0; m < 4; m++) begin
            for (int j = 0; j < 6; j++) begin
                send_word(loads[j], m[1], m[0]);
            end
        end
        // leave a known setting: low-speed 0x123 then try slow 0x1FF again
        send_word(9'h123, 1'b1, 1'b0);
        send_word(9'h1FF, 1'b1, 1'b0);
        check(2'b10, 9'h123, "R6 previous setting kept after rejected frame");
        send_word(9'h1FF, 1'b0, 1'b1);
        check(2'b01, 9'h1FF, "R6 0x1FF accepted in high-speed");
        send_word(9'h0C3, 1'b0, 1'b0);
        saved_m = exp_mode;
        saved_l = exp_load;

        // parallel sweep with latency boundary
        to_negedge();
        fmt_par_i = 1'b1;
        {pin_c_i, pin_b_i, pin_a_i} = 3'd0;
        repeat (5) to_negedge();
        for (int k = 1; k < 8; k++) begin
            {pin_c_i, pin_b_i, pin_a_i} = k[2:0];
            edges(2);
            check(2'b01, preset(k - 1), "R7 second edge still old");
            edges(1);
            check(2'b01, preset(k), "R7 parallel preset");
            to_negedge();
        end
        {pin_c_i, pin_b_i, pin_a_i} = 3'd0;
        repeat (5) to_negedge();
        check(2'b01, preset(0), "R7 parallel code 0");

        // enable low in parallel format
        enable_i = 1'b0;
        edges(2);
        check(2'b01, preset(0), "R8 second edge after disable still old");
        edges(1);
        check(2'b11, 9'h000, "R8 disabled in parallel");
        to_negedge();
        {pin_c_i, pin_b_i, pin_a_i} = 3'd5;
        repeat (5) to_negedge();
        check(2'b11, 9'h000, "R8 disabled ignores code");

        // back to serial, disabled; strobe low must not disturb hold
        pin_a_i = 1'b1;
        pin_b_i = 1'b0;
        fmt_par_i = 1'b0;
        repeat (6) to_negedge();
        check(2'b11, 9'h000, "R8 disabled in serial");
        enable_i = 1'b1;
        edges(3);
        check(saved_m, saved_l, "R10 R8 held setting restored");

        to_negedge();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule